// File: doc/BRIEF.md
# Received-pause transmit hold timer

This block holds off MAC data transmission after a flow-control pause frame has been received. A one-cycle pause-detect pulse carries a requested duration in slot times. The block raises a stop request toward the transmitter in that same cycle. It then waits for the transmitter to report that it has stopped between frames. When that report arrives, the block pulses a stop-complete interrupt and starts counting slot ticks. After the requested number of ticks it withdraws the stop request, and data frames may flow again. A status flag stays high for the whole time the transmitter is held by a received pause.

The slot counter is shared with the half-duplex collision backoff timer. The mode input selects which use is active. In full duplex the counter serves pause holds and backoff requests are ignored. In half duplex it times backoff intervals, and pause detects are ignored. The slot time of 512 bit times is supplied from outside as a periodic one-cycle tick.

Top module: `pause_hold_timer`

## Requirements
- R1: After reset, stop_req_o, rx_pause_o, gsc_irq_o and backoff_done_o are all 0.
- R2: With full_duplex_i=1, pause_det_i=1 drives stop_req_o high in the same cycle. From the next cycle, rx_pause_o is high and stop_req_o stays high until the hold ends.
- R3: With full_duplex_i=0, pause_det_i has no effect: stop_req_o and rx_pause_o stay 0.
- R4: gsc_irq_o is a one-cycle pulse in the cycle after tx_stopped_i is first seen high while waiting for the stop. tx_stopped_i seen while no pause is pending raises no pulse.
- R5: Slot ticks that arrive before the stopped acknowledge are not counted.
- R6: After the acknowledge, rx_pause_o and stop_req_o fall in the cycle after the N-th slot tick, where N is the requested duration (N>0). This holds up to the all-ones duration.
- R7: A duration of 0 releases the hold in the cycle after the acknowledge, with no ticks counted.
- R8: A new pause detect during a hold reloads the new duration and restarts the count from zero. It takes priority over a slot tick in the same cycle.
- R9: With full_duplex_i=0, backoff_start_i loads backoff_slots_i. backoff_done_o then pulses for one cycle after the N-th following slot tick. With N=0 it pulses in the cycle after the start.
- R10: With full_duplex_i=1, backoff_start_i has no effect and backoff_done_o stays 0.
- R11: Clearing full_duplex_i ends any pending or active hold. rx_pause_o and stop_req_o are 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_duplex_i | input | 1 | 1: counter times pause holds; 0: counter times collision backoff |
| pause_det_i | input | 1 | One-cycle pulse: valid pause frame received |
| pause_dur_i | input | DUR_W | Requested pause length in slot times |
| tx_stopped_i | input | 1 | Transmitter reports it has stopped between frames |
| slot_tick_i | input | 1 | One-cycle pulse every slot time |
| backoff_start_i | input | 1 | Start a backoff interval (half duplex) |
| backoff_slots_i | input | DUR_W | Backoff length in slot times |
| stop_req_o | output | 1 | Graceful stop request to the transmitter |
| gsc_irq_o | output | 1 | Stop-complete interrupt pulse |
| rx_pause_o | output | 1 | Transmitter is held by a received pause |
| backoff_done_o | output | 1 | Backoff interval finished pulse |

## Verification
The bench builds the block with DUR_W=4, so the all-ones duration of 15 slot times is reached in a few dozen cycles. This exercises the counter at its widest value, where the incremented count must still meet the limit without wrapping. The bench also covers a zero duration and ticks that arrive before the acknowledge, both of which stay hidden unless the count start is placed exactly at the acknowledge.

// File: rtl/pause_hold_timer.sv
module pause_hold_timer #(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             full_duplex_i,
  input  logic             pause_det_i,
  input  logic [DUR_W-1:0] pause_dur_i,
  input  logic             tx_stopped_i,
  input  logic             slot_tick_i,
  input  logic             backoff_start_i,
  input  logic [DUR_W-1:0] backoff_slots_i,
  output logic             stop_req_o,
  output logic             gsc_irq_o,
  output logic             rx_pause_o,
  output logic             backoff_done_o
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_HOLD} st_t;

  st_t             st;
  logic [DUR_W-1:0] cnt, lim;
  logic             bo_busy, irq_q, done_q;

  wire             det      = full_duplex_i & pause_det_i;
  wire             bo_go    = ~full_duplex_i & backoff_start_i;
  wire [DUR_W-1:0] cnt_inc  = cnt + 1'b1;
  wire             hit      = slot_tick_i && (cnt_inc == lim);
  wire [DUR_W-1:0] next_lim = det ? pause_dur_i : lim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      lim     <= '0;
      bo_busy <= 1'b0;
      irq_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      irq_q  <= 1'b0;
      done_q <= 1'b0;
      if (!full_duplex_i) begin
        st <= S_IDLE;
        if (bo_go) begin
          lim <= backoff_slots_i;
          cnt <= '0;
          if (backoff_slots_i == '0) begin
            done_q  <= 1'b1;
            bo_busy <= 1'b0;
          end else begin
            bo_busy <= 1'b1;
          end
        end else if (bo_busy && slot_tick_i) begin
          cnt <= cnt_inc;
          if (hit) begin
            bo_busy <= 1'b0;
            done_q  <= 1'b1;
          end
        end
      end else begin
        bo_busy <= 1'b0;
        case (st)
          S_IDLE: if (det) begin
            lim <= pause_dur_i;
            st  <= S_WAIT;
          end
          S_WAIT: if (tx_stopped_i) begin
            irq_q <= 1'b1;
            cnt   <= '0;
            lim   <= next_lim;
            st    <= (next_lim == '0) ? S_IDLE : S_HOLD;
          end else if (det) begin
            lim <= pause_dur_i;
          end
          S_HOLD: if (det) begin
            lim <= pause_dur_i;
            cnt <= '0;
            if (pause_dur_i == '0) st <= S_IDLE;
          end else if (slot_tick_i) begin
            cnt <= cnt_inc;
            if (hit) st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign rx_pause_o     = (st != S_IDLE);
  assign stop_req_o     = rx_pause_o | det;
  assign gsc_irq_o      = irq_q;
  assign backoff_done_o = done_q;

  assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gsc_irq_o |=> !gsc_irq_o);
  assert_irq_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gsc_irq_o |-> $past(tx_stopped_i));
  assert_wait_no_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && full_duplex_i && !tx_stopped_i) |=> (st == S_WAIT));
  assert_no_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD) |-> (cnt < lim));
  assert_hold_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && full_duplex_i && !pause_det_i && !slot_tick_i) |=> rx_pause_o);
  assert_bo_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bo_busy |-> (cnt < lim));
  assert_bo_halfdup_R10: assert property (@(posedge clk) disable iff (!rst_n)
    backoff_done_o |-> !$past(full_duplex_i));
  assert_halfdup_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !full_duplex_i |=> !rx_pause_o);

endmodule

// File: tb/pause_hold_timer_tb.sv
`timescale 1ns/1ps
module pause_hold_timer_tb;
  localparam int W = 4;
  // {duration, ticks before acknowledge}
  localparam logic [7:0] VEC [6] = '{8'h30, 8'h12, 8'h05, 8'hF0, 8'h01, 8'h43};

  logic clk = 0, rst_n = 0, fd = 1, det = 0, ack = 0, tick = 0, bo_start = 0;
  logic [W-1:0] dur = '0, bo_slots = '0;
  logic stop_req, irq, rxp, bo_done;
  int nvec = 0, nbad = 0;

  always #2 clk = ~clk;

  pause_hold_timer #(.DUR_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .full_duplex_i(fd), .pause_det_i(det),
    .pause_dur_i(dur), .tx_stopped_i(ack), .slot_tick_i(tick),
    .backoff_start_i(bo_start), .backoff_slots_i(bo_slots),
    .stop_req_o(stop_req), .gsc_irq_o(irq), .rx_pause_o(rxp),
    .backoff_done_o(bo_done));

  task automatic chk(string tag, logic act, logic exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    det = 0; tick = 0; bo_start = 0;
  endtask

  initial begin
    #400000;
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    cyc(); cyc();
    chk("R1 stop_req", stop_req, 0); chk("R1 rx_pause", rxp, 0);
    chk("R1 irq", irq, 0); chk("R1 backoff_done", bo_done, 0);
    rst_n = 1; cyc();

    foreach (VEC[k]) begin
      automatic int d = VEC[k][7:4];
      automatic int p = VEC[k][3:0];
      det = 1; dur = d[W-1:0]; #1;
      chk("R2 stop_req same cycle", stop_req, 1);
      cyc();
      chk("R2 rx_pause", rxp, 1);
      for (int i = 0; i < p; i++) begin tick = 1; cyc(); end
      chk("R5 held before ack", rxp, 1);
      chk("R4 no irq before ack", irq, 0);
      ack = 1; cyc();
      chk("R4 irq pulse", irq, 1);
      if (d == 0) chk("R7 zero duration release", rxp, 0);
      else chk("R6 held after ack", rxp, 1);
      for (int i = 0; i < d; i++) begin
        tick = 1; cyc();
        chk("R6 hold count", rxp, (i < d - 1));
        chk("R6 stop_req follows", stop_req, (i < d - 1));
      end
      ack = 0; cyc();
      chk("R4 irq single", irq, 0);
    end

    ack = 1; cyc(); cyc();
    chk("R4 no irq when idle", irq, 0);
    ack = 0;

    fd = 0; det = 1; dur = 4'd3; #1;
    chk("R3 stop_req", stop_req, 0);
    cyc();
    chk("R3 rx_pause", rxp, 0);
    fd = 1; cyc();

    det = 1; dur = 4'd5; cyc();
    ack = 1; cyc();
    for (int i = 0; i < 3; i++) begin tick = 1; cyc(); end
    det = 1; dur = 4'd2; tick = 1; cyc();
    chk("R8 reload keeps hold", rxp, 1);
    tick = 1; cyc();
    chk("R8 restarted count", rxp, 1);
    tick = 1; cyc();
    chk("R8 release after new duration", rxp, 0);
    ack = 0; cyc();

    det = 1; dur = 4'd9; cyc();
    ack = 1; cyc(); tick = 1; cyc();
    fd = 0; cyc();
    chk("R11 rx_pause dropped", rxp, 0);
    chk("R11 stop_req dropped", stop_req, 0);
    ack = 0;

    bo_start = 1; bo_slots = 4'd3; cyc();
    for (int i = 0; i < 3; i++) begin
      chk("R9 backoff not done", bo_done, 0);
      tick = 1; cyc();
    end
    chk("R9 backoff done", bo_done, 1);
    cyc();
    chk("R9 backoff done single", bo_done, 0);
    bo_start = 1; bo_slots = 4'd0; cyc();
    chk("R9 zero backoff", bo_done, 1);

    fd = 1; cyc();
    bo_start = 1; bo_slots = 4'd0; cyc();
    chk("R10 ignored in full duplex", bo_done, 0);
    tick = 1; cyc();
    chk("R10 still quiet", bo_done, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule